// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter with Serial Grant Chains

This block sits between a set of interrupting devices and a processor. It arbitrates their requests over four priority levels. Each device is wired to one of four shared request levels. While the arbiter is idle, it compares the levels that have a pending request against the processor's current 3-bit priority. It then picks the highest level that is strictly above that priority and sends a grant into the serial chain for that level.

Within a level, the grant reaches devices in chain order, starting with the position nearest the processor. A device with no request on that level lets the grant pass. The first device with a pending request on the level holds the grant until it is ready. It then supplies its vector, which is the address of a 4-byte block holding the new program counter and the new status word. The arbiter registers the vector and presents both word addresses to the processor. If a grant goes unanswered for a set number of cycles, the arbiter drops it and reports a spurious interrupt with a fixed vector.

Requests are level-held: a device keeps asserting its request until software services it. A request that is masked or has lost arbitration is therefore taken up again in a later arbitration round.

Top module: `vec_irq_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no request, no grant is driven, and `busy`, `intValid`, `spurious` and `intVector` are all zero.
- R2: A device's 2-bit level code L carries priority 4+L. A level may be granted only when 4+L is strictly greater than `cpuPri`. When several levels qualify, the largest one wins. With `cpuPri` at 7, nothing is granted.
- R3: On the granted level, the grant goes to the device with the lowest index among those requesting on that level. Devices without a request, and devices on other levels, never see it. If the holder withdraws its request, the grant moves on to the next requester on the same level. At most one `grantOut` bit is high.
- R4: An idle arbiter that samples an eligible request at a clock edge drives a grant from that edge on. The grant stays on the same level until it is answered or times out, and only one grant is outstanding.
- R5: When the device holding the grant has `devReady` high, then at the next edge `intValid` pulses for one cycle, `intVector` takes that device's vector, and the grant is dropped.
- R6: `intPcAddr` equals `intVector`, and `intPswAddr` equals `intVector` plus 2.
- R7: If a grant is outstanding for TIMEOUT cycles with no answer, `spurious` pulses for one cycle, `intVector` becomes SPUR_VEC, and the grant is dropped. This includes the case where no device on the chain is requesting.
- R8: A request that is masked by `cpuPri`, or that ended in a timeout, stays pending and is granted once it becomes eligible again.
- R9: A request on a higher level that arrives while a grant is outstanding does not change the granted level. It wins the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuPri | input | 3 | Current processor priority |
| devReq | input | N | Per-device held interrupt request |
| devLevel | input | 2*N | Per-device level code, device i at bits [2i+1:2i] |
| devReady | input | N | Per-device readiness to answer a grant |
| devVector | input | N*ADDR_W | Per-device vector, device i at bits [ADDR_W*i +: ADDR_W] |
| grantOut | output | N | Per-device grant as seen along the chains |
| busy | output | 1 | A grant is outstanding |
| intValid | output | 1 | One-cycle pulse: device vector captured |
| spurious | output | 1 | One-cycle pulse: grant timed out |
| intVector | output | ADDR_W | Last captured vector |
| intPcAddr | output | ADDR_W | Address of the new program counter |
| intPswAddr | output | ADDR_W | Address of the new status word |

## Verification
The first pattern is a single request, which sets the baseline latency and checks the vector addresses. Next, requests are placed on all levels and on shared levels at the same time. This separates level priority from chain position, because the drain order must run from the highest level down, and by index within a level. Further runs raise the processor priority to mask levels and then lower it, and they hold the grant with a device that is not ready. These show the difference between a masked request and a lost one, and measure the exact timeout length. Two final patterns check the chain's pass-on behaviour and the level lock: a holder withdraws its request in the middle of a grant, and a higher-level request arrives while a grant is outstanding.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int LEVELS = 4;
  localparam int LVL_W  = 2;
  localparam int PRI_W  = 3;

  typedef enum logic {ST_IDLE, ST_GRANT} arb_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             grantEn;
    logic [LVL_W-1:0] level;
    logic             capDev;
    logic             capSpur;
  } arb_ctl_t;

  function automatic logic [PRI_W-1:0] levelPri(input logic [LVL_W-1:0] code);
    return PRI_W'(4) + PRI_W'(code);
  endfunction
endpackage

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRI_W-1:0]  cpuPri,
  input  logic [LEVELS-1:0] levelReq,
  input  logic              answered,
  output arb_ctl_t          ctl
);
  localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  arb_state_e       state;
  logic [LVL_W-1:0] level;
  logic [TMR_W-1:0] timer;
  logic             found;
  logic [LVL_W-1:0] pickLvl;
  logic             timerDone;

  // highest level above processor priority
  always_comb begin
    found   = 1'b0;
    pickLvl = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (levelReq[l] && (levelPri(LVL_W'(l)) > cpuPri)) begin
        found   = 1'b1;
        pickLvl = LVL_W'(l);
      end
    end
  end

  assign timerDone   = (timer == TMR_W'(TIMEOUT - 1));
  assign ctl.grantEn = (state == ST_GRANT);
  assign ctl.level   = level;
  assign ctl.capDev  = ctl.grantEn & answered;
  assign ctl.capSpur = ctl.grantEn & ~answered & timerDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      level <= '0;
      timer <= '0;
    end else begin
      case (state)
        ST_IDLE: if (found) begin
          state <= ST_GRANT;
          level <= pickLvl;
          timer <= '0;
        end
        ST_GRANT: begin
          if (ctl.capDev || ctl.capSpur) state <= ST_IDLE;
          else timer <= timer + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a newly opened grant is on a level above the sampled priority
  p_eligible_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.grantEn) |-> (levelPri(ctl.level) > $past(cpuPri)));

  // R4: an unanswered, unexpired grant stays on the same level
  p_grant_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.grantEn && !ctl.capDev && !ctl.capSpur) |=> (ctl.grantEn && ctl.level == $past(ctl.level)));

  // R7: the wait counter never passes the timeout
  p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(timer) < TIMEOUT);
endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int N        = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SPUR_VEC = 16'h0004
) (
  input  logic                clk,
  input  logic                rstN,
  input  arb_ctl_t            ctl,
  input  logic [N-1:0]        devReq,
  input  logic [N*LVL_W-1:0]  devLevel,
  input  logic [N-1:0]        devReady,
  input  logic [N*ADDR_W-1:0] devVector,
  output logic [LEVELS-1:0]   levelReq,
  output logic                answered,
  output logic [N-1:0]        grantOut,
  output logic                intValid,
  output logic                spurious,
  output logic [ADDR_W-1:0]   intVector
);
  logic [LEVELS-1:0][N-1:0] reqMat;
  logic [N-1:0]             onGranted;
  logic [N-1:0]             chainIn;
  logic [ADDR_W-1:0]        pickedVec;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    for (genvar d = 0; d < N; d++) begin : g_dev
      assign reqMat[lv][d] = devReq[d] && (devLevel[d*LVL_W +: LVL_W] == LVL_W'(lv));
    end
    assign levelReq[lv] = |reqMat[lv];
  end

  // serial grant chain: index 0 sits nearest the processor
  assign chainIn[0] = ctl.grantEn;
  for (genvar d = 0; d < N; d++) begin : g_chain
    assign onGranted[d] = devReq[d] && (devLevel[d*LVL_W +: LVL_W] == ctl.level);
    assign grantOut[d]  = chainIn[d] & onGranted[d];
    if (d < N - 1) begin : g_pass
      assign chainIn[d+1] = chainIn[d] & ~onGranted[d];
    end
  end

  assign answered = |(grantOut & devReady);

  always_comb begin
    pickedVec = '0;
    for (int i = 0; i < N; i++)
      if (grantOut[i]) pickedVec = pickedVec | devVector[i*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intValid  <= 1'b0;
      spurious  <= 1'b0;
      intVector <= '0;
    end else begin
      intValid <= ctl.capDev;
      spurious <= ctl.capSpur;
      if (ctl.capDev)       intVector <= pickedVec;
      else if (ctl.capSpur) intVector <= SPUR_VEC;
    end
  end

  // R3: at most one device holds the grant
  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  // R5: the capture pulse lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    intValid |=> !intValid);

  // R5: the grant is gone once a result is reported
  p_grant_dropped_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intValid || spurious) |-> (grantOut == '0));

  // R7: a timeout and a capture never coincide
  p_spur_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(intValid && spurious));
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import vec_irq_pkg::*;
#(
  parameter int N        = 8,
  parameter int ADDR_W   = 16,
  parameter int TIMEOUT  = 16,
  parameter logic [ADDR_W-1:0] SPUR_VEC = 16'h0004
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cpuPri,
  input  logic [N-1:0]        devReq,
  input  logic [2*N-1:0]      devLevel,
  input  logic [N-1:0]        devReady,
  input  logic [N*ADDR_W-1:0] devVector,
  output logic [N-1:0]        grantOut,
  output logic                busy,
  output logic                intValid,
  output logic                spurious,
  output logic [ADDR_W-1:0]   intVector,
  output logic [ADDR_W-1:0]   intPcAddr,
  output logic [ADDR_W-1:0]   intPswAddr
);
  arb_ctl_t          ctl;
  logic [LEVELS-1:0] levelReq;
  logic              answered;

  vec_irq_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuPri(cpuPri),
    .levelReq(levelReq), .answered(answered), .ctl(ctl)
  );

  vec_irq_datapath #(.N(N), .ADDR_W(ADDR_W), .SPUR_VEC(SPUR_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .devReq(devReq), .devLevel(devLevel), .devReady(devReady), .devVector(devVector),
    .levelReq(levelReq), .answered(answered), .grantOut(grantOut),
    .intValid(intValid), .spurious(spurious), .intVector(intVector)
  );

  assign busy       = ctl.grantEn;
  assign intPcAddr  = intVector;
  assign intPswAddr = intVector + ADDR_W'(2);
endmodule

// File: tb/vec_irq_arbiter_test.sv
`timescale 1ns/1ps
module vec_irq_arbiter_test;
  localparam int N = 8;
  localparam int AW = 16;
  localparam int TO = 16;
  localparam logic [AW-1:0] SPUR = 16'h0004;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cpuPri = 3'd0;
  logic [N-1:0] devReq = '0;
  logic [2*N-1:0] devLevel;
  logic [N-1:0] devReady = '1;
  logic [N*AW-1:0] devVector;
  logic [N-1:0] grantOut;
  logic busy, intValid, spurious;
  logic [AW-1:0] intVector, intPcAddr, intPswAddr;

  int checks = 0;
  int errors = 0;
  int lvlTab [N] = '{0, 1, 2, 2, 3, 1, 3, 0};

  always #4 clk = ~clk;  // 125 MHz

  vec_irq_arbiter #(.N(N), .ADDR_W(AW), .TIMEOUT(TO), .SPUR_VEC(SPUR)) uut (
    .clk(clk), .rstN(rstN), .cpuPri(cpuPri), .devReq(devReq), .devLevel(devLevel),
    .devReady(devReady), .devVector(devVector), .grantOut(grantOut), .busy(busy),
    .intValid(intValid), .spurious(spurious), .intVector(intVector),
    .intPcAddr(intPcAddr), .intPswAddr(intPswAddr)
  );

  function automatic logic [AW-1:0] vecOf(int i);
    return AW'(16'h0100 + 4 * i);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      devLevel[2*i +: 2] = 2'(lvlTab[i]);
      devVector[AW*i +: AW] = vecOf(i);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mBusy, mValid, mSpur;
  int mLevel, mTimer;
  logic [AW-1:0] mVec;

  function automatic int taker();
    if (!mBusy) return -1;
    for (int i = 0; i < N; i++)
      if (devReq[i] && lvlTab[i] == mLevel) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mValid = 0; mSpur = 0; mLevel = 0; mTimer = 0; mVec = '0;
    end else begin
      int t;
      t = taker();
      mValid = 0; mSpur = 0;
      if (!mBusy) begin
        for (int l = 0; l < 4; l++)
          for (int i = 0; i < N; i++)
            if (devReq[i] && lvlTab[i] == l && (4 + l) > int'(cpuPri)) begin
              mBusy = 1; mLevel = l; mTimer = 0;
            end
      end else if (t >= 0 && devReady[t]) begin
        mValid = 1; mVec = vecOf(t); mBusy = 0;
      end else if (mTimer == TO - 1) begin
        mSpur = 1; mVec = SPUR; mBusy = 0;
      end else begin
        mTimer++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [N-1:0] expG;
      int t;
      t = taker();
      expG = '0;
      if (t >= 0) expG[t] = 1'b1;
      chk(grantOut === expG, "R3 grant", grantOut, expG);
      chk(busy === mBusy, "R4 busy", busy, mBusy);
      chk(intValid === mValid, "R5 intValid", intValid, mValid);
      chk(spurious === mSpur, "R7 spurious", spurious, mSpur);
      chk(intVector === mVec, "R5 intVector", intVector, mVec);
      chk(intPcAddr === mVec, "R6 pc address", intPcAddr, mVec);
      chk(intPswAddr === mVec + AW'(2), "R6 status address", intPswAddr, mVec + AW'(2));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
    if (intValid)
      for (int i = 0; i < N; i++)
        if (intVector == vecOf(i)) devReq[i] = 1'b0;  // service clears request
  endtask

  task automatic waitOut(output logic [AW-1:0] v, output bit s, output int c);
    c = 0; s = 0; v = '0;
    while (c < 200) begin
      step(); c++;
      if (intValid || spurious) begin
        v = intVector; s = spurious;
        return;
      end
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [AW-1:0] v;
    bit s;
    int c;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(grantOut == '0 && !busy && !intValid && !spurious && intVector == '0, "R1 in reset",
        {grantOut, busy, intValid, spurious, intVector}, 0);
    @(posedge clk); #2; rstN = 1'b1;
    repeat (3) step();
    chk(grantOut == '0 && !busy && intVector == '0, "R1 idle after reset", {grantOut, busy}, 0);

    // R5/R6: single request, grant one edge later, vector the edge after
    devReq[1] = 1'b1;
    waitOut(v, s, c);
    chk(v == vecOf(1) && !s, "R5 single vector", v, vecOf(1));
    chk(c == 2, "R4 grant latency", c, 2);
    chk(intPswAddr == vecOf(1) + 2, "R6 status word address", intPswAddr, vecOf(1) + 2);

    // R2/R3: level then chain order
    devReq[0] = 1; devReq[2] = 1; devReq[3] = 1; devReq[4] = 1;
    waitOut(v, s, c); chk(v == vecOf(4), "R2 highest level first", v, vecOf(4));
    waitOut(v, s, c); chk(v == vecOf(2), "R3 nearest on level", v, vecOf(2));
    waitOut(v, s, c); chk(v == vecOf(3), "R3 next on level", v, vecOf(3));
    waitOut(v, s, c); chk(v == vecOf(0), "R2 lowest level last", v, vecOf(0));

    // R8: masked request is kept and served later
    cpuPri = 3'd6; devReq[2] = 1; devReq[6] = 1;
    waitOut(v, s, c); chk(v == vecOf(6), "R2 only level above priority", v, vecOf(6));
    repeat (10) step();
    chk(!busy && devReq[2], "R8 masked request held", busy, 0);
    cpuPri = 3'd0;
    waitOut(v, s, c); chk(v == vecOf(2), "R8 masked request served", v, vecOf(2));

    // R2: priority 7 masks everything
    cpuPri = 3'd7; devReq[6] = 1;
    repeat (8) step();
    chk(!busy && grantOut == '0, "R2 all masked", busy, 0);
    cpuPri = 3'd6;
    waitOut(v, s, c); chk(v == vecOf(6), "R2 seven above six", v, vecOf(6));

    // R7: holder never ready -> timeout after TO grant cycles
    cpuPri = 3'd0; devReady[5] = 0; devReq[5] = 1;
    waitOut(v, s, c);
    chk(s && v == SPUR, "R7 spurious vector", v, SPUR);
    chk(c == TO + 1, "R7 timeout length", c, TO + 1);
    devReady[5] = 1;
    waitOut(v, s, c); chk(v == vecOf(5) && !s, "R8 request after timeout", v, vecOf(5));

    // R3: holder withdraws, grant passes down the chain
    devReady[1] = 0; devReq[1] = 1; devReq[5] = 1;
    repeat (4) step();
    chk(grantOut == 8'b0000_0010, "R3 blocked holder", grantOut, 8'b0000_0010);
    devReq[1] = 0;
    waitOut(v, s, c); chk(v == vecOf(5), "R3 grant passed on", v, vecOf(5));
    devReady[1] = 1;

    // R9: higher request during grant waits for next round
    devReady[0] = 0; devReq[0] = 1;
    repeat (3) step();
    devReq[4] = 1;
    waitOut(v, s, c); chk(s, "R9 level locked until timeout", s, 1);
    devReady[0] = 1;
    waitOut(v, s, c); chk(v == vecOf(4), "R9 higher wins next round", v, vecOf(4));
    waitOut(v, s, c); chk(v == vecOf(0), "R8 lower served after", v, vecOf(0));

    // R7: request withdrawn after grant -> nobody answers
    devReq[7] = 1;
    step();
    devReq[7] = 0;
    waitOut(v, s, c); chk(s && v == SPUR, "R7 empty chain times out", v, SPUR);

    repeat (4) step();
    finishRun();
  end
endmodule